// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a processor core out of reset. Once reset is released it reads two words from the start of memory through a plain read port with request, address, ready and read data. The first word becomes the initial main stack pointer. The second word is the entry address of the startup routine. The sequencer loads that address into the program counter with bit 0 cleared, and it copies bit 0 into the execution-state (T) bit.

The link register is held at all ones from reset onward. The core is reported as being in thread mode at privileged level. The run-enable output stays low until both words are loaded. If the fetched entry address has bit 0 at zero, the sequencer raises a fault output and leaves run-enable low. An active-low reset at any moment abandons the sequence, and the sequence then starts again from the first read.

Top module: `boot_vector_seq`

## Requirements
- R1: The first read after reset release uses address 0x0000_0000, and the word it returns is stored on `msp_out`.
- R2: The second read uses address 0x0000_0004, and the word it returns is used as the program counter value.
- R3: The read at 0x0000_0004 is not requested until the read at 0x0000_0000 has completed, meaning `rd_req` and `rd_ready` were both high on a clock edge.
- R4: `lr_out` reads 0xFFFF_FFFF while reset is asserted and at every point after it.
- R5: `tbit_out` equals bit 0 of the word returned by the second read.
- R6: `pc_out` equals the second word with bit 0 forced to 0.
- R7: `handler_mode` is 0 (thread mode) and `unpriv` is 0 (privileged level) whenever execution is enabled.
- R8: If bit 0 of the second word is 0, `boot_fault` goes high and `run_en` stays low.
- R9: While `rd_req` is high and `rd_ready` is low, `rd_req` stays high and `rd_addr` stays unchanged on the next cycle. Any number of wait cycles is accepted.
- R10: `run_en` is low during reset and during the whole fetch. It rises in the cycle after the second read completes, and only if bit 0 of the second word is 1. Once high it stays high until reset. With W1 and W2 wait cycles on the two reads, `run_en` is high 3+W1+W2 cycles after reset release.
- R11: Asserting reset at any point drops `rd_req` and `run_en`. After release, the first request is again to 0x0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address, held while the request waits |
| rd_ready | input | 1 | Read completes on a clock edge where this and rd_req are high |
| rd_data | input | DATA_W | Read data, valid with rd_ready |
| msp_out | output | DATA_W | Loaded main stack pointer |
| pc_out | output | ADDR_W | Loaded program counter, bit 0 cleared |
| lr_out | output | DATA_W | Link register preset, all ones |
| tbit_out | output | 1 | Execution-state bit taken from the entry word |
| handler_mode | output | 1 | 0 = thread mode |
| unpriv | output | 1 | 0 = privileged level |
| run_en | output | 1 | Core may start executing |
| boot_fault | output | 1 | Entry word had bit 0 clear |

## Verification
Two actions can land on the same clock edge: the stack-pointer read completes and the program-counter request is issued in the very next cycle. With zero wait states on both reads, the two loads happen on adjacent edges with no idle cycle between them. The bench provokes this with a near-exhaustive sweep of wait counts 0 to 3 on each read, for both values of the T bit. In every run it checks that the address moves from 0 to 4 only after the first completion, that the address stays put while a read waits, and that run-enable or the fault rises in exactly the cycle given by the wait counts. A further run asserts reset while the second read is stalled and checks that the next request goes back to address 0.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD   = 3'd0,
      ST_GET_SP = 3'd1,
      ST_GET_PC = 3'd2,
      ST_RUN    = 3'd3,
      ST_FAULT  = 3'd4
   } boot_state_t;

   function automatic logic is_fetch(input boot_state_t s);
      return (s == ST_GET_SP) || (s == ST_GET_PC);
   endfunction

endpackage

// File: rtl/boot_rd_port.sv
module boot_rd_port
   import boot_seq_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter logic [31:0] SP_VEC_ADDR = 32'h0000_0000,
   parameter logic [31:0] PC_VEC_ADDR = 32'h0000_0004
) (
   input  boot_state_t       state,
   input  logic              rd_ready,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              sp_done,
   output logic              pc_done
);
   localparam logic [ADDR_W-1:0] SP_A = SP_VEC_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] PC_A = PC_VEC_ADDR[ADDR_W-1:0];

   // request and address come only from the registered state, so both
   // stay steady for as long as the state waits on ready
   always_comb begin
      rd_req  = is_fetch(state);
      rd_addr = (state == ST_GET_PC) ? PC_A : SP_A;
      sp_done = (state == ST_GET_SP) && rd_ready;
      pc_done = (state == ST_GET_PC) && rd_ready;
   end

endmodule

// File: rtl/boot_vec_capture.sv
module boot_vec_capture #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_we,
   input  logic              pc_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] msp_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] lr_q,
   output logic              tbit_q
);
   localparam int PC_SRC_W = (DATA_W < ADDR_W) ? DATA_W : ADDR_W;

   logic [ADDR_W-1:0] pc_next;

   generate
      if (DATA_W >= ADDR_W) begin : g_pc_trunc
         assign pc_next = {wdata[ADDR_W-1:1], 1'b0};
      end else begin : g_pc_zext
         assign pc_next = {{(ADDR_W-PC_SRC_W){1'b0}}, wdata[PC_SRC_W-1:1], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msp_q  <= '0;
         pc_q   <= '0;
         lr_q   <= '1;
         tbit_q <= 1'b0;
      end else begin
         if (sp_we) msp_q <= wdata;
         if (pc_we) begin
            pc_q   <= pc_next;
            tbit_q <= wdata[0];
         end
      end
   end

   assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |=> $stable(pc_q) && $stable(tbit_q))
      else $error("assert_sp_load_leaves_pc_R3");

endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
   import boot_seq_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 32,
   parameter logic [31:0] SP_VEC_ADDR = 32'h0000_0000,
   parameter logic [31:0] PC_VEC_ADDR = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] msp_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] lr_out,
   output logic              tbit_out,
   output logic              handler_mode,
   output logic              unpriv,
   output logic              run_en,
   output logic              boot_fault
);
   localparam int BYTES = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_dw
         $error("DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie in 3..32");
      end
      if (SP_VEC_ADDR == PC_VEC_ADDR) begin : g_bad_vec
         $error("vector addresses must differ");
      end
      if ((SP_VEC_ADDR % BYTES) != 0 || (PC_VEC_ADDR % BYTES) != 0) begin : g_bad_align
         $error("vector addresses must be word aligned");
      end
   endgenerate

   boot_state_t state, state_nx;
   logic        sp_done, pc_done;

   always_comb begin
      state_nx = state;
      case (state)
         ST_HOLD:   state_nx = ST_GET_SP;
         ST_GET_SP: if (sp_done) state_nx = ST_GET_PC;
         ST_GET_PC: if (pc_done) state_nx = rd_data[0] ? ST_RUN : ST_FAULT;
         default:   state_nx = state;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_HOLD;
      else        state <= state_nx;
   end

   boot_rd_port #(
      .ADDR_W      (ADDR_W),
      .SP_VEC_ADDR (SP_VEC_ADDR),
      .PC_VEC_ADDR (PC_VEC_ADDR)
   ) u_port (
      .state    (state),
      .rd_ready (rd_ready),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .sp_done  (sp_done),
      .pc_done  (pc_done)
   );

   boot_vec_capture #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .sp_we  (sp_done),
      .pc_we  (pc_done),
      .wdata  (rd_data),
      .msp_q  (msp_out),
      .pc_q   (pc_out),
      .lr_q   (lr_out),
      .tbit_q (tbit_out)
   );

   assign run_en       = (state == ST_RUN);
   assign boot_fault   = (state == ST_FAULT);
   assign handler_mode = 1'b0;
   assign unpriv       = 1'b0;

   assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)))
      else $error("assert_hold_request_R9");

   assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_addr == PC_VEC_ADDR[ADDR_W-1:0]
       && !$past(rd_req && rd_addr == PC_VEC_ADDR[ADDR_W-1:0]))
      |-> $past(rd_req && rd_ready && rd_addr == SP_VEC_ADDR[ADDR_W-1:0]))
      else $error("assert_sp_before_pc_R3");

   assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> $past(rd_req && rd_ready
                              && rd_addr == PC_VEC_ADDR[ADDR_W-1:0] && rd_data[0]))
      else $error("assert_run_after_loads_R10");

   assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> run_en)
      else $error("assert_run_sticky_R10");

   assert property (@(posedge clk) disable iff (!rst_n)
      boot_fault |-> (!run_en && !tbit_out && !rd_req))
      else $error("assert_fault_blocks_run_R8");

endmodule

// File: tb/tb_boot_vector_seq.sv
`timescale 1ns/1ps
module tb_boot_vector_seq;
   localparam int DW = 32;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ready = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic [DW-1:0] msp_out, lr_out;
   logic [AW-1:0] pc_out;
   logic          tbit_out, handler_mode, unpriv, run_en, boot_fault;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   boot_vector_seq #(.DATA_W(DW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_data(rd_data), .msp_out(msp_out),
      .pc_out(pc_out), .lr_out(lr_out), .tbit_out(tbit_out),
      .handler_mode(handler_mode), .unpriv(unpriv), .run_en(run_en),
      .boot_fault(boot_fault)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic do_reset();
      rd_ready = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(lr_out == 32'hFFFF_FFFF, "R4 lr in reset", lr_out, 32'hFFFF_FFFF);
      chk(!run_en && !rd_req, "R10 idle in reset", {run_en, rd_req}, 0);
      rst_n = 1'b1;
   endtask

   // memory model: answers at negedge after wsp / wpc stalled cycles
   task automatic run_boot(input logic [31:0] spv, input logic [31:0] pcv,
                           input int wsp, input int wpc);
      int          csp = 0, cpc = 0, guard = 0;
      logic        spd = 1'b0, pend = 1'b0, fin = 1'b0;
      logic [31:0] paddr = '0;
      do_reset();
      while (!fin && guard < 200) begin
         @(negedge clk);
         guard++;
         if (pend)
            chk(rd_req && rd_addr == paddr, "R9 held request", rd_addr, paddr);
         if (run_en || boot_fault) begin
            fin = 1'b1;
            rd_ready = 1'b0;
         end else begin
            rd_ready = 1'b0;
            pend = 1'b0;
            if (rd_req) begin
               if (rd_addr == 32'h0) begin
                  chk(!spd, "R3 stack word read once", 1, 0);
                  if (csp == wsp) begin
                     rd_ready = 1'b1; rd_data = spv; spd = 1'b1;
                  end else begin
                     csp++; pend = 1'b1; paddr = rd_addr;
                  end
               end else if (rd_addr == 32'h4) begin
                  if (cpc == 0 && !pend) chk(spd, "R3 order", 0, 1);
                  if (cpc == wpc) begin
                     rd_ready = 1'b1; rd_data = pcv;
                  end else begin
                     cpc++; pend = 1'b1; paddr = rd_addr;
                  end
               end else begin
                  chk(1'b0, "R1 R2 address", rd_addr, 0);
               end
            end
         end
      end
      chk(guard == 3 + wsp + wpc, "R10 start cycle", guard, 3 + wsp + wpc);
      chk(msp_out == spv, "R1 stack pointer", msp_out, spv);
      chk(pc_out == (pcv & 32'hFFFF_FFFE), "R2 R6 program counter", pc_out,
          pcv & 32'hFFFF_FFFE);
      chk(tbit_out == pcv[0], "R5 T bit", tbit_out, pcv[0]);
      chk(run_en == pcv[0], "R10 run enable", run_en, pcv[0]);
      chk(boot_fault == !pcv[0], "R8 fault", boot_fault, !pcv[0]);
      chk(!handler_mode && !unpriv, "R7 thread privileged", {handler_mode, unpriv}, 0);
      chk(lr_out == 32'hFFFF_FFFF, "R4 lr after boot", lr_out, 32'hFFFF_FFFF);
      chk(!rd_req, "R10 no request after boot", rd_req, 0);
      repeat (3) @(negedge clk);
      chk(run_en == pcv[0], "R10 run stays", run_en, pcv[0]);
   endtask

   initial begin
      for (int ws = 0; ws < 4; ws++) begin
         for (int wp = 0; wp < 4; wp++) begin
            for (int t = 0; t < 2; t++) begin
               logic [31:0] spv, pcv;
               spv = 32'h2000_0000 + 32'(ws * 64 + wp * 16 + t * 4);
               pcv = 32'h0800_0100 + 32'(ws * 32 + wp * 8) + 32'(t);
               run_boot(spv, pcv, ws, wp);
            end
         end
      end

      // reset while the second read stalls, then check restart
      do_reset();
      @(negedge clk);
      rd_ready = 1'b1; rd_data = 32'h2000_1000;
      @(negedge clk);
      rd_ready = 1'b0;
      repeat (2) @(negedge clk);
      chk(rd_req && rd_addr == 32'h4, "R9 second read stalled", rd_addr, 32'h4);
      rst_n = 1'b0;
      #1;
      chk(!rd_req && !run_en, "R11 reset drops request", {rd_req, run_en}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_req && rd_addr == 32'h0, "R11 restart from first read", rd_addr, 32'h0);
      run_boot(32'h2000_2000, 32'h0000_0201, 0, 2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule